// File: doc/BRIEF.md
# Fetch and Load/Store Port Sequencer

This block is the control state machine that sits between an in-order core and two memory ports, one for instruction fetch and one for data, that speak a valid/accept handshake. It sends one request at a time. When a port refuses a request, the block parks in a retry state for that port and offers the same request again only when the port raises its retry line. When a port accepts, the block waits as many cycles as the port needs before the response comes back. It keeps four saturating counters of stall and retry cycles, measured against a free-running cycle counter.

The fetched word is latched and offered to the core for one execute cycle. In that cycle the core says whether the instruction needs a data access, and gives its address, direction and write data. Reads return their data through a load-complete strobe. A switch-out request stops the block. If a data access is in flight, the switch waits for its response. Responses that arrive once the block is switched out are absorbed. Only reset leaves the switched-out state.

Top module: `mem_port_sequencer`

## Requirements
- R1: In the running state, unless switch-out is requested, the block raises `i_req_valid` for exactly one cycle with `i_req_addr` equal to `core_pc` with bits 1:0 cleared.
- R2: An accepted fetch (`i_req_ready` high with valid) leads to a response wait with no further request. A refused fetch leads to a retry state in which `i_req_valid` stays low until `i_retry` is seen.
- R3: In a retry state, `i_retry` (or `d_retry`) re-presents the held request in that same cycle with unchanged fields. It adds the cycles elapsed since the stall began to `iretry_cnt` (or `dretry_cnt`). An accepted re-send moves to the response wait; a refused one stays in the retry state.
- R4: An instruction response adds the elapsed stall cycles to `istall_cnt` and latches `i_resp_data`.
- R5: In the cycle after an instruction response, `exec_valid` is high with the latched word on `exec_inst` and no fetch is issued. If `exec_mem` is low, fetching resumes in the next cycle.
- R6: In the execute cycle with `exec_mem` high, the block issues a data request carrying `exec_addr`, `exec_wr` (1 = write) and `exec_wdata`, and holds them for any retry. Accept and refusal behave as in R2.
- R7: A data response adds the elapsed stall cycles to `dstall_cnt`. For a read, it raises `ld_valid` in the same cycle with `ld_data` equal to `d_resp_data`. Fetching resumes in the next cycle.
- R8: A switch-out request during a data wait without a response moves to a wait-switch state. The following data response completes the access (including `ld_valid` for a read) without adding to `dstall_cnt`. The block then switches out.
- R9: A switch-out request in any other active state takes priority over everything else in that cycle and goes straight to switched-out. `sw_ack` is high for exactly the first switched-out cycle.
- R10: When switched out, responses are absorbed, no request is issued, no counter changes and no further `sw_ack` occurs.
- R11: A response or retry seen in a state that does not expect it sets `proto_err`. The flag stays set until reset, and the event does not alter the state.
- R12: Stall timestamps come from a cycle counter that starts at zero at reset. All four counters saturate at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_pc | input | AW | Program counter from the core |
| sw_req | input | 1 | Switch-out request |
| exec_mem | input | 1 | Executed instruction needs a data access |
| exec_wr | input | 1 | Data access is a write |
| exec_addr | input | AW | Data access address |
| exec_wdata | input | DW | Data access write data |
| i_req_valid | output | 1 | Fetch request valid |
| i_req_addr | output | AW | Fetch address, word aligned |
| i_req_ready | input | 1 | Fetch port accepts |
| i_retry | input | 1 | Fetch port invites a re-send |
| i_resp_valid | input | 1 | Fetch response |
| i_resp_data | input | IW | Fetched instruction word |
| d_req_valid | output | 1 | Data request valid |
| d_req_addr | output | AW | Data address |
| d_req_wr | output | 1 | Data request is a write |
| d_req_wdata | output | DW | Data write value |
| d_req_ready | input | 1 | Data port accepts |
| d_retry | input | 1 | Data port invites a re-send |
| d_resp_valid | input | 1 | Data response |
| d_resp_data | input | DW | Data read value |
| exec_valid | output | 1 | Latched instruction offered for execution |
| exec_inst | output | IW | Latched instruction word |
| ld_valid | output | 1 | Read access complete |
| ld_data | output | DW | Read data |
| sw_ack | output | 1 | Switched-out acknowledge pulse |
| proto_err | output | 1 | Sticky protocol-error flag |
| istall_cnt | output | CNT_W | Fetch stall cycles |
| iretry_cnt | output | CNT_W | Fetch retry cycles |
| dstall_cnt | output | CNT_W | Data stall cycles |
| dretry_cnt | output | CNT_W | Data retry cycles |

## Verification
A wrong state shows up at the ports within a cycle. A missing retry state makes a request appear without `i_retry`/`d_retry`. A lost access-complete state drops or duplicates `exec_valid`. A wrongly deferred switch moves `sw_ack` by at least one cycle, or produces a request after the acknowledge. A bad stall timestamp changes a counter value on the cycle after the response or retry that used it. The bench therefore compares every output against a behavioural model on every cycle, with port stimulus that follows the model's expected state.

// File: rtl/mps_pkg.sv
`timescale 1ns/1ps
package mps_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_IRETRY, ST_IWAIT, ST_IDONE,
    ST_DRETRY, ST_DWAIT, ST_DWAITSW, ST_SWOUT
  } seq_state_e;

  localparam int NCNT       = 4;
  localparam int CNT_ISTALL = 0;
  localparam int CNT_IRETRY = 1;
  localparam int CNT_DSTALL = 2;
  localparam int CNT_DRETRY = 3;
endpackage

// File: rtl/mps_ctrl.sv
`timescale 1ns/1ps
module mps_ctrl
  import mps_pkg::*;
#(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic             exec_mem,
  input  logic             i_req_ready,
  input  logic             i_retry,
  input  logic             i_resp_valid,
  input  logic             d_req_ready,
  input  logic             d_retry,
  input  logic             d_resp_valid,
  output logic             i_req_valid,
  output logic             i_fresh,
  output logic             d_req_valid,
  output logic             d_fresh,
  output logic             fetch_load,
  output logic             inst_load,
  output logic             dhold_load,
  output logic             exec_valid,
  output logic             d_take,
  output logic             sw_ack,
  output logic             proto_err,
  output logic [NCNT-1:0]  cnt_en,
  output logic [CYC_W-1:0] delta
);
  seq_state_e       st, nxt;
  logic [CYC_W-1:0] cyc, t0;
  logic             stamp, viol, perr_q, ack_q;

  // next-state and strobe decode
  always_comb begin
    nxt         = st;
    i_req_valid = 1'b0;
    d_req_valid = 1'b0;
    fetch_load  = 1'b0;
    inst_load   = 1'b0;
    dhold_load  = 1'b0;
    exec_valid  = 1'b0;
    d_take      = 1'b0;
    stamp       = 1'b0;
    cnt_en      = '0;
    case (st)
      ST_RUN: begin
        if (sw_req) nxt = ST_SWOUT;
        else begin
          i_req_valid = 1'b1;
          fetch_load  = 1'b1;
          stamp       = 1'b1;
          nxt         = i_req_ready ? ST_IWAIT : ST_IRETRY;
        end
      end
      ST_IRETRY: begin
        if (sw_req) nxt = ST_SWOUT;
        else if (i_retry) begin
          i_req_valid        = 1'b1;
          cnt_en[CNT_IRETRY] = 1'b1;
          if (i_req_ready) nxt = ST_IWAIT;
        end
      end
      ST_IWAIT: begin
        if (sw_req) nxt = ST_SWOUT;
        else if (i_resp_valid) begin
          cnt_en[CNT_ISTALL] = 1'b1;
          inst_load          = 1'b1;
          nxt                = ST_IDONE;
        end
      end
      ST_IDONE: begin
        if (sw_req) nxt = ST_SWOUT;
        else begin
          exec_valid = 1'b1;
          if (exec_mem) begin
            d_req_valid = 1'b1;
            dhold_load  = 1'b1;
            stamp       = 1'b1;
            nxt         = d_req_ready ? ST_DWAIT : ST_DRETRY;
          end else begin
            nxt = ST_RUN;
          end
        end
      end
      ST_DRETRY: begin
        if (sw_req) nxt = ST_SWOUT;
        else if (d_retry) begin
          d_req_valid        = 1'b1;
          cnt_en[CNT_DRETRY] = 1'b1;
          if (d_req_ready) nxt = ST_DWAIT;
        end
      end
      ST_DWAIT: begin
        if (d_resp_valid) begin
          d_take             = 1'b1;
          cnt_en[CNT_DSTALL] = 1'b1;
          nxt                = sw_req ? ST_SWOUT : ST_RUN;
        end else if (sw_req) begin
          nxt = ST_DWAITSW;
        end
      end
      ST_DWAITSW: begin
        if (d_resp_valid) begin
          d_take = 1'b1;
          nxt    = ST_SWOUT;
        end
      end
      default: nxt = st;
    endcase
  end

  always_comb begin
    viol = (i_resp_valid && !(st == ST_IWAIT || st == ST_SWOUT)) ||
           (d_resp_valid && !(st == ST_DWAIT || st == ST_DWAITSW || st == ST_SWOUT)) ||
           (i_retry && st != ST_IRETRY) ||
           (d_retry && st != ST_DRETRY);
  end

  assign i_fresh   = (st == ST_RUN);
  assign d_fresh   = (st == ST_IDONE);
  assign delta     = cyc - t0;
  assign sw_ack    = ack_q;
  assign proto_err = perr_q;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      cyc    <= '0;
      t0     <= '0;
      perr_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st     <= nxt;
      cyc    <= cyc + 1'b1;
      if (stamp) t0 <= cyc;
      perr_q <= perr_q | viol;
      ack_q  <= (nxt == ST_SWOUT) && (st != ST_SWOUT);
    end
  end

  assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |=> !sw_ack);
  assert_quiet_switched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |-> (!i_req_valid && !d_req_valid));
  assert_exec_follows_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> ($past(i_resp_valid) && !i_req_valid));
  assert_retry_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req_valid && !d_fresh) |-> d_retry);
endmodule

// File: rtl/mps_hold.sv
`timescale 1ns/1ps
module mps_hold #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_load,
  input  logic          inst_load,
  input  logic          dhold_load,
  input  logic          i_fresh,
  input  logic          d_fresh,
  input  logic [AW-1:0] core_pc,
  input  logic [IW-1:0] i_resp_data,
  input  logic          exec_wr,
  input  logic [AW-1:0] exec_addr,
  input  logic [DW-1:0] exec_wdata,
  output logic [AW-1:0] i_req_addr,
  output logic [IW-1:0] exec_inst,
  output logic [AW-1:0] d_req_addr,
  output logic          d_req_wr,
  output logic [DW-1:0] d_req_wdata,
  output logic          rd_pend
);
  localparam int LOW_BITS = 2;

  logic [AW-1:0] pc_al, fa_q, da_q;
  logic [IW-1:0] inst_q;
  logic [DW-1:0] dw_q;
  logic          wr_q;

  assign pc_al = {core_pc[AW-1:LOW_BITS], {LOW_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q   <= '0;
      inst_q <= '0;
      da_q   <= '0;
      dw_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      if (fetch_load) fa_q <= pc_al;
      if (inst_load)  inst_q <= i_resp_data;
      if (dhold_load) begin
        da_q <= exec_addr;
        dw_q <= exec_wdata;
        wr_q <= exec_wr;
      end
    end
  end

  assign i_req_addr  = i_fresh ? pc_al : fa_q;
  assign exec_inst   = inst_q;
  assign d_req_addr  = d_fresh ? exec_addr  : da_q;
  assign d_req_wr    = d_fresh ? exec_wr    : wr_q;
  assign d_req_wdata = d_fresh ? exec_wdata : dw_q;
  assign rd_pend     = !wr_q;
endmodule

// File: rtl/mps_sat_acc.sv
`timescale 1ns/1ps
module mps_sat_acc #(
  parameter int CNT_W = 16,
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CYC_W-1:0] delta,
  output logic [CNT_W-1:0] acc
);
  localparam int SUM_W = ((CNT_W > CYC_W) ? CNT_W : CYC_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'({CNT_W{1'b1}});

  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] acc_d;

  always_comb begin
    sum   = SUM_W'(acc) + SUM_W'(delta);
    acc_d = (sum > LIMIT) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc_d;
  end

  assert_no_decrease_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (acc >= $past(acc)));
  assert_hold_at_max_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == {CNT_W{1'b1}}) |=> (acc == {CNT_W{1'b1}}));
endmodule

// File: rtl/mem_port_sequencer.sv
`timescale 1ns/1ps
module mem_port_sequencer
  import mps_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IW    = 32,
  parameter int CYC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    core_pc,
  input  logic             sw_req,
  input  logic             exec_mem,
  input  logic             exec_wr,
  input  logic [AW-1:0]    exec_addr,
  input  logic [DW-1:0]    exec_wdata,
  output logic             i_req_valid,
  output logic [AW-1:0]    i_req_addr,
  input  logic             i_req_ready,
  input  logic             i_retry,
  input  logic             i_resp_valid,
  input  logic [IW-1:0]    i_resp_data,
  output logic             d_req_valid,
  output logic [AW-1:0]    d_req_addr,
  output logic             d_req_wr,
  output logic [DW-1:0]    d_req_wdata,
  input  logic             d_req_ready,
  input  logic             d_retry,
  input  logic             d_resp_valid,
  input  logic [DW-1:0]    d_resp_data,
  output logic             exec_valid,
  output logic [IW-1:0]    exec_inst,
  output logic             ld_valid,
  output logic [DW-1:0]    ld_data,
  output logic             sw_ack,
  output logic             proto_err,
  output logic [CNT_W-1:0] istall_cnt,
  output logic [CNT_W-1:0] iretry_cnt,
  output logic [CNT_W-1:0] dstall_cnt,
  output logic [CNT_W-1:0] dretry_cnt
);
  logic             i_fresh, d_fresh, fetch_load, inst_load, dhold_load;
  logic             d_take, rd_pend;
  logic [NCNT-1:0]  cnt_en;
  logic [CYC_W-1:0] delta;
  logic [CNT_W-1:0] cnt_q [NCNT];

  mps_ctrl #(.CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .exec_mem(exec_mem),
    .i_req_ready(i_req_ready), .i_retry(i_retry), .i_resp_valid(i_resp_valid),
    .d_req_ready(d_req_ready), .d_retry(d_retry), .d_resp_valid(d_resp_valid),
    .i_req_valid(i_req_valid), .i_fresh(i_fresh), .d_req_valid(d_req_valid),
    .d_fresh(d_fresh), .fetch_load(fetch_load), .inst_load(inst_load),
    .dhold_load(dhold_load), .exec_valid(exec_valid), .d_take(d_take),
    .sw_ack(sw_ack), .proto_err(proto_err), .cnt_en(cnt_en), .delta(delta)
  );

  mps_hold #(.AW(AW), .DW(DW), .IW(IW)) u_hold (
    .clk(clk), .rst_n(rst_n), .fetch_load(fetch_load), .inst_load(inst_load),
    .dhold_load(dhold_load), .i_fresh(i_fresh), .d_fresh(d_fresh),
    .core_pc(core_pc), .i_resp_data(i_resp_data), .exec_wr(exec_wr),
    .exec_addr(exec_addr), .exec_wdata(exec_wdata), .i_req_addr(i_req_addr),
    .exec_inst(exec_inst), .d_req_addr(d_req_addr), .d_req_wr(d_req_wr),
    .d_req_wdata(d_req_wdata), .rd_pend(rd_pend)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    mps_sat_acc #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(cnt_en[g]), .delta(delta), .acc(cnt_q[g])
    );
  end

  assign istall_cnt = cnt_q[CNT_ISTALL];
  assign iretry_cnt = cnt_q[CNT_IRETRY];
  assign dstall_cnt = cnt_q[CNT_DSTALL];
  assign dretry_cnt = cnt_q[CNT_DRETRY];
  assign ld_valid   = d_take && rd_pend;
  assign ld_data    = d_resp_data;

  assert_load_only_on_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (d_resp_valid && !d_req_valid));
endmodule

// File: tb/mem_port_sequencer_bench.sv
`timescale 1ns/1ps
module mem_port_sequencer_bench;
  localparam int AW = 32, DW = 32, IW = 32, CYC_W = 16, CNT_W = 8;
  localparam int CMAX = 255;
  localparam int S_RUN = 0, S_IRT = 1, S_IWT = 2, S_IDN = 3,
                 S_DRT = 4, S_DWT = 5, S_DWS = 6, S_SWO = 7;

  logic clk = 1'b0, rst_n;
  logic [AW-1:0] core_pc, exec_addr, i_req_addr, d_req_addr;
  logic [DW-1:0] exec_wdata, d_req_wdata, d_resp_data, ld_data;
  logic [IW-1:0] i_resp_data, exec_inst;
  logic sw_req, exec_mem, exec_wr, i_req_valid, i_req_ready, i_retry, i_resp_valid;
  logic d_req_valid, d_req_wr, d_req_ready, d_retry, d_resp_valid;
  logic exec_valid, ld_valid, sw_ack, proto_err;
  logic [CNT_W-1:0] istall_cnt, iretry_cnt, dstall_cnt, dretry_cnt;

  always #4 clk = ~clk;

  mem_port_sequencer #(.AW(AW), .DW(DW), .IW(IW), .CYC_W(CYC_W), .CNT_W(CNT_W)) u_mem_port_sequencer (
    .clk(clk), .rst_n(rst_n), .core_pc(core_pc), .sw_req(sw_req), .exec_mem(exec_mem),
    .exec_wr(exec_wr), .exec_addr(exec_addr), .exec_wdata(exec_wdata),
    .i_req_valid(i_req_valid), .i_req_addr(i_req_addr), .i_req_ready(i_req_ready),
    .i_retry(i_retry), .i_resp_valid(i_resp_valid), .i_resp_data(i_resp_data),
    .d_req_valid(d_req_valid), .d_req_addr(d_req_addr), .d_req_wr(d_req_wr),
    .d_req_wdata(d_req_wdata), .d_req_ready(d_req_ready), .d_retry(d_retry),
    .d_resp_valid(d_resp_valid), .d_resp_data(d_resp_data), .exec_valid(exec_valid),
    .exec_inst(exec_inst), .ld_valid(ld_valid), .ld_data(ld_data), .sw_ack(sw_ack),
    .proto_err(proto_err), .istall_cnt(istall_cnt), .iretry_cnt(iretry_cnt),
    .dstall_cnt(dstall_cnt), .dretry_cnt(dretry_cnt)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // behavioural reference
  int mst, mcyc, mt0;
  int mcnt [4];
  logic [AW-1:0] mfa, mda;
  logic [DW-1:0] mdw;
  logic [IW-1:0] minst;
  bit mdwr, mperr, mack, mdefer;

  task automatic chk(string req, string what, longint act, longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mst = S_RUN; mcyc = 0; mt0 = 0; mperr = 0; mack = 0; mdefer = 0;
    mfa = '0; mda = '0; mdw = '0; minst = '0; mdwr = 0;
    for (int k = 0; k < 4; k++) mcnt[k] = 0;
  endtask

  function automatic int sat(int a, int d);
    return (a + d > CMAX) ? CMAX : a + d;
  endfunction

  task automatic model_step();
    int nst, dl;
    bit stamp, viol;
    nst = mst; stamp = 0;
    dl = (mcyc - mt0) & 16'hFFFF;
    viol = (i_resp_valid && !(mst == S_IWT || mst == S_SWO)) ||
           (d_resp_valid && !(mst == S_DWT || mst == S_DWS || mst == S_SWO)) ||
           (i_retry && mst != S_IRT) || (d_retry && mst != S_DRT);
    case (mst)
      S_RUN: if (sw_req) nst = S_SWO;
             else begin
               mfa = {core_pc[AW-1:2], 2'b00}; stamp = 1;
               nst = i_req_ready ? S_IWT : S_IRT;
             end
      S_IRT: if (sw_req) nst = S_SWO;
             else if (i_retry) begin
               mcnt[1] = sat(mcnt[1], dl);
               if (i_req_ready) nst = S_IWT;
             end
      S_IWT: if (sw_req) nst = S_SWO;
             else if (i_resp_valid) begin
               mcnt[0] = sat(mcnt[0], dl); minst = i_resp_data; nst = S_IDN;
             end
      S_IDN: if (sw_req) nst = S_SWO;
             else if (exec_mem) begin
               mda = exec_addr; mdw = exec_wdata; mdwr = exec_wr; stamp = 1;
               nst = d_req_ready ? S_DWT : S_DRT;
             end else nst = S_RUN;
      S_DRT: if (sw_req) nst = S_SWO;
             else if (d_retry) begin
               mcnt[3] = sat(mcnt[3], dl);
               if (d_req_ready) nst = S_DWT;
             end
      S_DWT: if (d_resp_valid) begin
               mcnt[2] = sat(mcnt[2], dl); nst = sw_req ? S_SWO : S_RUN;
             end else if (sw_req) nst = S_DWS;
      S_DWS: if (d_resp_valid) nst = S_SWO;
      default: nst = mst;
    endcase
    mack = (nst == S_SWO) && (mst != S_SWO);
    mdefer = mack && (mst == S_DWS);
    mperr = mperr | viol;
    if (stamp) mt0 = mcyc;
    mcyc = mcyc + 1;
    mst = nst;
  endtask

  task automatic compare_all();
    bit e_iv, e_ex, e_dv, e_ld, e_dwr;
    logic [AW-1:0] e_ia, e_da;
    logic [DW-1:0] e_dw;
    string ti, td;
    e_iv = !sw_req && (mst == S_RUN || (mst == S_IRT && i_retry));
    e_ia = (mst == S_RUN) ? {core_pc[AW-1:2], 2'b00} : mfa;
    e_ex = (mst == S_IDN) && !sw_req;
    e_dv = (e_ex && exec_mem) || (!sw_req && mst == S_DRT && d_retry);
    e_da = (mst == S_IDN) ? exec_addr : mda;
    e_dw = (mst == S_IDN) ? exec_wdata : mdw;
    e_dwr = (mst == S_IDN) ? exec_wr : mdwr;
    e_ld = d_resp_valid && (mst == S_DWT || mst == S_DWS) && !mdwr;
    ti = (mst == S_SWO) ? "R10" : (mst == S_IRT) ? "R3" : "R2";
    td = (mst == S_SWO) ? "R10" : (mst == S_DRT) ? "R3" : "R6";
    chk(ti, "i_req_valid", i_req_valid, e_iv);
    if (e_iv) chk((mst == S_IRT) ? "R3" : "R1", "i_req_addr", i_req_addr, e_ia);
    chk(td, "d_req_valid", d_req_valid, e_dv);
    if (e_dv) begin
      chk(td, "d_req_addr", d_req_addr, e_da);
      chk(td, "d_req_wdata", d_req_wdata, e_dw);
      chk(td, "d_req_wr", d_req_wr, e_dwr);
    end
    chk("R5", "exec_valid", exec_valid, e_ex);
    if (e_ex) chk("R4", "exec_inst", exec_inst, minst);
    chk((mst == S_DWS) ? "R8" : "R7", "ld_valid", ld_valid, e_ld);
    if (e_ld) chk("R7", "ld_data", ld_data, d_resp_data);
    chk(mdefer ? "R8" : "R9", "sw_ack", sw_ack, mack);
    chk("R11", "proto_err", proto_err, mperr);
    chk((mcnt[0] == CMAX) ? "R12" : "R4", "istall_cnt", istall_cnt, mcnt[0]);
    chk((mcnt[1] == CMAX) ? "R12" : "R3", "iretry_cnt", iretry_cnt, mcnt[1]);
    chk((mcnt[2] == CMAX) ? "R12" : "R7", "dstall_cnt", dstall_cnt, mcnt[2]);
    chk((mcnt[3] == CMAX) ? "R12" : "R3", "dretry_cnt", dretry_cnt, mcnt[3]);
  endtask

  task automatic drive(bit swm, bit errm);
    core_pc = $urandom; exec_addr = $urandom; exec_wdata = $urandom;
    exec_mem = $urandom_range(1, 0); exec_wr = $urandom_range(1, 0);
    i_resp_data = $urandom; d_resp_data = $urandom;
    i_req_ready = ($urandom_range(2, 0) != 0);
    d_req_ready = ($urandom_range(2, 0) != 0);
    if (errm) begin
      i_retry = ($urandom_range(4, 0) == 0); d_retry = ($urandom_range(4, 0) == 0);
      i_resp_valid = ($urandom_range(4, 0) == 0); d_resp_valid = ($urandom_range(4, 0) == 0);
      sw_req = ($urandom_range(29, 0) == 0);
    end else begin
      i_retry = (mst == S_IRT) && ($urandom_range(1, 0) == 0);
      d_retry = (mst == S_DRT) && ($urandom_range(1, 0) == 0);
      i_resp_valid = (mst == S_IWT || mst == S_SWO) && ($urandom_range(3, 0) == 0);
      d_resp_valid = (mst == S_DWT || mst == S_DWS || mst == S_SWO) && ($urandom_range(3, 0) == 0);
      sw_req = swm && (((mst == S_DWT) && ($urandom_range(3, 0) == 0)) ||
                       ($urandom_range(39, 0) == 0));
    end
  endtask

  task automatic run_cycles(int n, bit swm, bit errm);
    for (int k = 0; k < n; k++) begin
      drive(swm, errm);
      #1;
      compare_all();
      @(posedge clk);
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sw_req = 0; exec_mem = 0; exec_wr = 0; exec_addr = '0; exec_wdata = '0;
    i_req_ready = 0; i_retry = 0; i_resp_valid = 0; i_resp_data = '0;
    d_req_ready = 0; d_retry = 0; d_resp_valid = 0; d_resp_data = '0;
    core_pc = 32'h0000_0013;
    model_reset();
    @(negedge clk);
    #1;
    // reset state: counters clear, no error, no ack, fetch from aligned pc
    chk("R12", "istall_cnt at reset", istall_cnt, 0);
    chk("R12", "dretry_cnt at reset", dretry_cnt, 0);
    chk("R11", "proto_err at reset", proto_err, 0);
    chk("R9", "sw_ack at reset", sw_ack, 0);
    chk("R1", "i_req_valid at reset", i_req_valid, 1);
    chk("R1", "i_req_addr at reset", i_req_addr, 32'h0000_0010);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    run_cycles(3000, 0, 0);
    chk("R12", "istall_cnt saturated", istall_cnt, CMAX);
    for (int s = 0; s < 8; s++) begin
      do_reset();
      run_cycles(150, 1, 0);
    end
    do_reset();
    run_cycles(300, 0, 1);
    chk("R11", "proto_err after stray events", proto_err, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule